// File: doc/BRIEF.md
# Bus Grant Idle Watchdog

This block sits beside the master side of a PCI-style bus interface that serves one requester. It watches for a device that has been given the bus but never starts a transaction. When the grant is held and the bus stays idle with no cycle start for a programmable number of consecutive clocks, 16 by default, the block declares the device broken. It then raises a sticky status bit, sends a one-cycle error response to the requester that is waiting, and sends a one-cycle pulse to the master-error bit of a separate error-cause register.

The same block records master-side terminations. A master abort means that no target claimed the cycle, and a received target abort ends the cycle from the other side. Each of these sets its own sticky bit and produces an error response. Two parity conditions only set sticky bits: a parity error on incoming read data, and a data parity error seen on the bus while acting as master. Software clears sticky bits with a write-one-to-clear strobe and mask.

A control input switches off the grant timeout. While that input is set, the idle count stays at zero. There is no streaming data path, so every pin is a plain level or strobe, and there is no back-pressure to handle.

Top module: `grant_idle_watchdog`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), status_o is all zeros and err_rsp_o and cause_pulse_o are low.
- R2: A clock is qualifying when gnt_i=1, bus_idle_i=1, cyc_start_i=0 and tmo_off_i=0. On the IDLE_LIMIT-th consecutive qualifying clock edge, the block sets status_o[2] (broken device). In the cycle that follows that edge, err_rsp_o and cause_pulse_o are both high.
- R3: The run of qualifying clocks restarts from zero when grant drops, when the bus is not idle, or when a cycle starts. A run of IDLE_LIMIT-1 qualifying clocks followed by any of these events produces no broken-device event.
- R4: One uninterrupted qualifying run produces at most one broken-device event, however long it lasts.
- R5: While tmo_off_i=1, no broken-device event occurs and the count is held at zero. After release, a full run of IDLE_LIMIT qualifying clocks is needed.
- R6: A master abort strobe (mst_abort_i) at an edge sets status_o[0] and gives a one-cycle err_rsp_o in the next cycle, with no cause_pulse_o.
- R7: A target abort strobe (tgt_abort_i) at an edge sets status_o[1] and gives a one-cycle err_rsp_o in the next cycle, with no cause_pulse_o.
- R8: rd_perr_i sets status_o[3] and bus_perr_i sets status_o[4]. Neither produces err_rsp_o or cause_pulse_o.
- R9: A clock edge with clr_we_i=1 clears exactly those status bits whose clr_mask_i bit is 1. All other bits are unchanged.
- R10: If an event and a clear of the same status bit fall on the same edge, the bit ends up set.
- R11: err_rsp_o is high for one cycle after each edge that has at least one abort or broken-device event. Coincident events merge into a single pulse. cause_pulse_o is high only after broken-device edges, and never without err_rsp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt_i | input | 1 | Bus grant held for this requester |
| bus_idle_i | input | 1 | Bus is idle this clock |
| cyc_start_i | input | 1 | A bus cycle starts this clock |
| mst_abort_i | input | 1 | Master abort strobe (no target claimed the cycle) |
| tgt_abort_i | input | 1 | Target abort received strobe |
| rd_perr_i | input | 1 | Parity error on incoming read data |
| bus_perr_i | input | 1 | Data parity error seen on the bus as master |
| tmo_off_i | input | 1 | Disables the grant idle timeout |
| clr_we_i | input | 1 | Write-one-to-clear strobe for status bits |
| clr_mask_i | input | 5 | Bits to clear when clr_we_i is high |
| status_o | output | 5 | Sticky bits: [0] master abort, [1] target abort, [2] broken device, [3] read parity, [4] bus data parity |
| err_rsp_o | output | 1 | One-cycle error response to the pending requester |
| cause_pulse_o | output | 1 | One-cycle pulse to the master-error cause bit |

## Verification
The hardest situation to reach is the boundary of the idle run: exactly IDLE_LIMIT-1 qualifying clocks followed by a break in each of its three forms, then a long run that must fire once and only once. The stimulus builds these runs with directed loops whose lengths are set relative to IDLE_LIMIT. It also releases the timeout disable in the middle of a run, and it places an event and its clear on the same edge. A long random phase follows, with grant and idle biased high so that full runs still happen. Throughout both phases, a behavioural model is compared with the outputs on every clock.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int unsigned ST_W      = 5;
  localparam int unsigned ST_MABORT = 0;
  localparam int unsigned ST_TABORT = 1;
  localparam int unsigned ST_BROKEN = 2;
  localparam int unsigned ST_RDPERR = 3;
  localparam int unsigned ST_BSPERR = 4;

  typedef logic [ST_W-1:0] st_vec_t;

  typedef struct packed {
    logic rsp;
    logic cause;
  } rsp_req_t;
endpackage

// File: rtl/gw_idle_timer.sv
module gw_idle_timer #(
  parameter int unsigned IDLE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic idle,
  input  logic start,
  input  logic dis,
  output logic fire
);
  localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(IDLE_LIMIT);

  logic [CNT_W-1:0] cnt;
  logic             qual;

  assign qual = gnt && idle && !start && !dis;
  assign fire = qual && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!qual) begin
      cnt <= '0;
    end else if (cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SAT); // R4
  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R4
  AST_GRANT_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt || start || !idle) |=> (cnt == '0)); // R3
  AST_DISABLE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (cnt == '0)); // R5
endmodule

// File: rtl/gw_sticky_bank.sv
module gw_sticky_bank #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[b] <= 1'b0;
      end else if (set_vec[b]) begin
        q[b] <= 1'b1;
      end else if (clr_we && clr_mask[b]) begin
        q[b] <= 1'b0;
      end
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[b] && clr_we && clr_mask[b]) |=> q[b]); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_vec[b] && clr_we && clr_mask[b]) |=> !q[b]); // R9
    AST_HOLD_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_vec[b] && !(clr_we && clr_mask[b])) |=> $stable(q[b])); // R9
  end
endmodule

// File: rtl/gw_resp_gen.sv
module gw_resp_gen
  import gw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     abort_evt,
  input  logic     broken_evt,
  output rsp_req_t out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out <= '0;
    end else begin
      out.rsp   <= abort_evt || broken_evt;
      out.cause <= broken_evt;
    end
  end

  AST_CAUSE_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    out.cause |-> out.rsp); // R11
  AST_ABORT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> out.rsp); // R6
endmodule

// File: rtl/grant_idle_watchdog.sv
module grant_idle_watchdog
  import gw_pkg::*;
#(
  parameter int unsigned IDLE_LIMIT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt_i,
  input  logic            bus_idle_i,
  input  logic            cyc_start_i,
  input  logic            mst_abort_i,
  input  logic            tgt_abort_i,
  input  logic            rd_perr_i,
  input  logic            bus_perr_i,
  input  logic            tmo_off_i,
  input  logic            clr_we_i,
  input  logic [ST_W-1:0] clr_mask_i,
  output logic [ST_W-1:0] status_o,
  output logic            err_rsp_o,
  output logic            cause_pulse_o
);
  logic     broken;
  st_vec_t  events;
  rsp_req_t rsp;

  gw_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .gnt   (gnt_i),
    .idle  (bus_idle_i),
    .start (cyc_start_i),
    .dis   (tmo_off_i),
    .fire  (broken)
  );

  always_comb begin
    events            = '0;
    events[ST_MABORT] = mst_abort_i;
    events[ST_TABORT] = tgt_abort_i;
    events[ST_BROKEN] = broken;
    events[ST_RDPERR] = rd_perr_i;
    events[ST_BSPERR] = bus_perr_i;
  end

  gw_sticky_bank #(.W(ST_W)) u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (events),
    .clr_we   (clr_we_i),
    .clr_mask (clr_mask_i),
    .q        (status_o)
  );

  gw_resp_gen u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_evt  (mst_abort_i || tgt_abort_i),
    .broken_evt (broken),
    .out        (rsp)
  );

  assign err_rsp_o     = rsp.rsp;
  assign cause_pulse_o = rsp.cause;

  AST_MABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mst_abort_i |=> (status_o[ST_MABORT] && err_rsp_o)); // R6
  AST_TABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_abort_i |=> (status_o[ST_TABORT] && err_rsp_o)); // R7
  AST_CAUSE_SETS_BROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cause_pulse_o |-> status_o[ST_BROKEN]); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_off_i |=> !cause_pulse_o); // R5
  AST_PARITY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_abort_i && !tgt_abort_i && !broken) |=> !err_rsp_o); // R8
endmodule

// File: tb/grant_idle_watchdog_bench.sv
module grant_idle_watchdog_bench;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gnt = 0, idle = 0, start = 0, mab = 0, tab = 0, rdp = 0, bsp = 0, dis = 0, clr = 0;
  logic [4:0] mask = '0;
  logic [4:0] status;
  logic       rsp, cause;

  int    vectors = 0;
  int    miscompares = 0;
  bit    comparing = 0;
  string phase = "R1";

  int         m_cnt = 0;
  logic [4:0] m_st = '0;
  logic       m_rsp = 0, m_cause = 0;

  always #(PERIOD/2) clk = ~clk;

  grant_idle_watchdog #(.IDLE_LIMIT(LIMIT)) u_grant_idle_watchdog (
    .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .bus_idle_i(idle), .cyc_start_i(start),
    .mst_abort_i(mab), .tgt_abort_i(tab), .rd_perr_i(rdp), .bus_perr_i(bsp),
    .tmo_off_i(dis), .clr_we_i(clr), .clr_mask_i(mask),
    .status_o(status), .err_rsp_o(rsp), .cause_pulse_o(cause)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    bit qual, brk;
    logic [4:0] ev;
    if (!rst_n) begin
      m_cnt = 0; m_st = '0; m_rsp = 0; m_cause = 0;
    end else begin
      qual = gnt && idle && !start && !dis;
      brk  = qual && (m_cnt == LIMIT - 1);
      if (!qual) m_cnt = 0;
      else if (m_cnt < LIMIT) m_cnt = m_cnt + 1;
      ev = {bsp, rdp, brk, tab, mab};
      for (int b = 0; b < 5; b++) begin
        if (ev[b]) m_st[b] = 1'b1;
        else if (clr && mask[b]) m_st[b] = 1'b0;
      end
      m_rsp   = mab || tab || brk;
      m_cause = brk;
    end
  end

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual {status,rsp,cause}=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) check(phase, {status, rsp, cause}, {m_st, m_rsp, m_cause});
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet();
    gnt = 0; idle = 0; start = 0; mab = 0; tab = 0; rdp = 0; bsp = 0; dis = 0; clr = 0; mask = '0;
  endtask

  task automatic clear_all();
    clr = 1; mask = 5'h1f; cyc(1); clr = 0; mask = '0; cyc(1);
  endtask

  initial begin
    #(PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    quiet();
    cyc(3);
    phase = "R1";
    check("R1", {status, rsp, cause}, 7'b0);
    rst_n = 1;
    comparing = 1;
    cyc(2);

    // R2 and R4: full run, then keep it going
    phase = "R2";
    gnt = 1; idle = 1;
    cyc(LIMIT - 1);
    check("R2", {status, rsp, cause}, 7'b0);
    cyc(1);
    check("R2", {status, rsp, cause}, {5'b00100, 2'b11});
    phase = "R4";
    cyc(LIMIT * 2);
    check("R4", {status, rsp, cause}, {5'b00100, 2'b00});
    quiet(); cyc(1);
    clear_all();

    // R3: each break at LIMIT-1
    phase = "R3";
    gnt = 1; idle = 1;
    cyc(LIMIT - 1); start = 1; cyc(1); start = 0;
    cyc(LIMIT - 1); idle = 0; cyc(1); idle = 1;
    cyc(LIMIT - 1); gnt = 0; cyc(1); gnt = 1;
    cyc(LIMIT - 1);
    check("R3", {status, rsp, cause}, 7'b0);
    cyc(1);
    check("R3", {status, rsp, cause}, {5'b00100, 2'b11});
    quiet(); cyc(1);
    clear_all();

    // R5: disable, then release mid-run
    phase = "R5";
    gnt = 1; idle = 1; dis = 1;
    cyc(LIMIT * 3);
    check("R5", {status, rsp, cause}, 7'b0);
    dis = 0;
    cyc(LIMIT - 1);
    check("R5", {status, rsp, cause}, 7'b0);
    cyc(1);
    check("R5", {status, rsp, cause}, {5'b00100, 2'b11});
    quiet(); cyc(1);
    clear_all();

    // R6, R7, R11, R8
    phase = "R6";
    mab = 1; cyc(1); mab = 0;
    check("R6", {status, rsp, cause}, {5'b00001, 2'b10});
    cyc(1);
    check("R6", {status, rsp, cause}, {5'b00001, 2'b00});
    phase = "R7";
    tab = 1; cyc(1); tab = 0;
    check("R7", {status, rsp, cause}, {5'b00011, 2'b10});
    phase = "R11";
    mab = 1; tab = 1; cyc(1); mab = 0; tab = 0;
    check("R11", {status, rsp, cause}, {5'b00011, 2'b10});
    cyc(1);
    check("R11", {status, rsp, cause}, {5'b00011, 2'b00});
    phase = "R8";
    rdp = 1; cyc(1); rdp = 0; bsp = 1; cyc(1); bsp = 0;
    check("R8", {status, rsp, cause}, {5'b11011, 2'b00});

    // R9 partial clear, R10 set beats clear
    phase = "R9";
    clr = 1; mask = 5'b01001; cyc(1); clr = 0; mask = '0;
    check("R9", {status, rsp, cause}, {5'b10010, 2'b00});
    phase = "R10";
    clr = 1; mask = 5'b11111; mab = 1; cyc(1); clr = 0; mask = '0; mab = 0;
    check("R10", {status, rsp, cause}, {5'b00001, 2'b10});
    clear_all();

    // random phase, R11 on mixed traffic
    phase = "R11";
    for (int i = 0; i < 3000; i++) begin
      gnt   = ($urandom_range(0, 19) != 0);
      idle  = ($urandom_range(0, 24) != 0);
      start = ($urandom_range(0, 29) == 0);
      dis   = ($urandom_range(0, 39) == 0);
      mab   = ($urandom_range(0, 19) == 0);
      tab   = ($urandom_range(0, 19) == 0);
      rdp   = ($urandom_range(0, 29) == 0);
      bsp   = ($urandom_range(0, 29) == 0);
      clr   = ($urandom_range(0, 9) == 0);
      mask  = 5'($urandom);
      cyc(1);
    end
    quiet(); cyc(2);

    comparing = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule